// File: doc/BRIEF.md
# Interrupt-Sensing GPIO Pin Bank

This block is a 32-pin general-purpose I/O bank that sits on a simple 32-bit register bus. Software sets, per pin, whether the pin drives or listens. It writes the value to drive, and it reads back the levels seen on the pins. Output enables and output data leave the block as plain vectors that the pad ring consumes.

Each pin can also raise an interrupt event. The pin is first passed through a two-flop synchronizer. It is then watched for one of five conditions: low level, high level, rising edge, falling edge, or any edge. A detected condition sets a sticky status bit. The bit stays set until software writes a one to it. A mask register selects which status bits reach the two interrupt request lines. One line serves the lower half of the bank and the other serves the upper half.

Top module: `gpio_pinbank`

## Requirements
- R1: While reset is asserted, every register reads 0. The outputs pin_out, pin_oe, irq_lo and irq_hi are all 0.
- R2: The output-data word at byte offset 0x00 reads back the value last written, not the pin levels, and it drives pin_out. The direction word at 0x04 drives pin_oe, where bit value 1 means the pin is an output.
- R3: The pad word at 0x08 returns pin_in after two synchronizing flops. A change on pin_in made between clock edges is still invisible after the first rising edge and is visible after the second.
- R4: Pin n takes a 2-bit sense code from bits [2*(n mod 16)+1 : 2*(n mod 16)] of a configuration word. Pins 0–15 use the word at 0x0C and pins 16–31 use the word at 0x10. The codes are: 00 = low level, 01 = high level, 10 = rising edge, 11 = falling edge.
- R5: When bit n of the any-edge word at 0x1C is 1, pin n detects both rising and falling edges and its 2-bit sense code is ignored.
- R6: The status word at 0x18 is sticky. Writing 1 to a bit clears it, and writing 0 leaves that bit unchanged.
- R7: If a detected condition occurs in the same cycle as a clearing write to its bit, the status bit stays set. This covers both a level that is still true and a fresh edge.
- R8: irq_lo is the OR over bits 0–15 of (status AND mask), and irq_hi is the same OR over bits 16–31. The mask word is at 0x14.
- R9: Bus writes take effect at the next rising clock edge. Reads at an offset that is unaligned or above 0x1C return 0, and writes there change no register.
- R10: An edge is found by comparing the synchronized level with its value one cycle earlier. A pin change made between clock edges sets its status bit at the third rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | AW | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_in | input | NPINS | Raw pin levels from the pads |
| pin_out | output | NPINS | Output data for the pads |
| pin_oe | output | NPINS | Output enable for each pin |
| irq_lo | output | 1 | Interrupt request for the lower half of the pins |
| irq_hi | output | 1 | Interrupt request for the upper half of the pins |

## Verification
The bench uses the default build: NPINS = 32, SYNC_STAGES = 2 and AW = 8. Both configuration words are therefore full, and both interrupt lines are live. The any-edge override and the four sense codes are rotated across all 32 pins. Every pin is driven in every mode through transition pairs that the bench evaluates with its own bitwise arithmetic. With AW = 8, offsets above the register map can be reached, so unmapped reads and writes can be tested. The bench also times one edge so that it lands on the same cycle as a clearing write, which tests the event-over-clear priority and the three-edge latency.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int BUS_W = 32;

    typedef enum logic [3:0] {
        RS_DOUT, RS_DIR, RS_PAD, RS_CFG_LO, RS_CFG_HI,
        RS_MASK, RS_STAT, RS_ANYEDGE, RS_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_HIGH = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_FALL = 2'b11
    } sense_e;

    typedef struct packed {
        logic cur;
        logic last;
    } pin_sample_t;

    // Byte offset to register select; unaligned or out-of-map offsets give RS_NONE.
    function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
        if (ofs[1:0] != 2'b00) return RS_NONE;
        case (ofs[31:2])
            30'd0:   return RS_DOUT;
            30'd1:   return RS_DIR;
            30'd2:   return RS_PAD;
            30'd3:   return RS_CFG_LO;
            30'd4:   return RS_CFG_HI;
            30'd5:   return RS_MASK;
            30'd6:   return RS_STAT;
            30'd7:   return RS_ANYEDGE;
            default: return RS_NONE;
        endcase
    endfunction

    // One pin's detection for this cycle.
    function automatic logic sense_hit(input logic [1:0] code, input logic any_edge,
                                       input pin_sample_t s);
        logic up, down;
        up   = s.cur & ~s.last;
        down = ~s.cur & s.last;
        if (any_edge) return up | down;
        case (sense_e'(code))
            SENSE_LOW:  return ~s.cur;
            SENSE_HIGH: return s.cur;
            SENSE_RISE: return up;
            default:    return down;
        endcase
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] raw,
    output logic [NPINS-1:0] synced
);
    logic [NPINS-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= raw;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/gpb_sense.sv
module gpb_sense import gpb_pkg::*; #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] cfg_lo,
    input  logic [NPINS-1:0] cfg_hi,
    input  logic [NPINS-1:0] any_edge,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] stat_q
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] hit;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [1:0]  code;
        pin_sample_t smp;
        if (p < HALF) begin : g_lo
            assign code = cfg_lo[2*p +: 2];
        end else begin : g_hi
            assign code = cfg_hi[2*(p-HALF) +: 2];
        end
        assign smp    = '{cur: lvl[p], last: prev_q[p]};
        assign hit[p] = sense_hit(code, any_edge[p], smp);
    end

    // A fresh event wins over a clearing write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            stat_q <= '0;
        end else begin
            prev_q <= lvl;
            stat_q <= hit | (stat_q & ~clr);
        end
    end
endmodule

// File: rtl/gpb_regs.sv
module gpb_regs import gpb_pkg::*; #(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic [NPINS-1:0] pad_lvl,
    input  logic [NPINS-1:0] stat_q,
    output logic [NPINS-1:0] dout_q,
    output logic [NPINS-1:0] dir_q,
    output logic [NPINS-1:0] cfg_lo_q,
    output logic [NPINS-1:0] cfg_hi_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] anyedge_q,
    output logic [NPINS-1:0] stat_clr
);
    reg_sel_e         sel;
    logic [NPINS-1:0] wval;

    assign sel  = decode_offset(32'(bus_addr));
    assign wval = bus_wdata[NPINS-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q    <= '0;
            dir_q     <= '0;
            cfg_lo_q  <= '0;
            cfg_hi_q  <= '0;
            mask_q    <= '0;
            anyedge_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                RS_DOUT:    dout_q    <= wval;
                RS_DIR:     dir_q     <= wval;
                RS_CFG_LO:  cfg_lo_q  <= wval;
                RS_CFG_HI:  cfg_hi_q  <= wval;
                RS_MASK:    mask_q    <= wval;
                RS_ANYEDGE: anyedge_q <= wval;
                default:    ;
            endcase
        end
    end

    assign stat_clr = (bus_wr && sel == RS_STAT) ? wval : '0;

    always_comb begin
        bus_rdata = '0;
        case (sel)
            RS_DOUT:    bus_rdata[NPINS-1:0] = dout_q;
            RS_DIR:     bus_rdata[NPINS-1:0] = dir_q;
            RS_PAD:     bus_rdata[NPINS-1:0] = pad_lvl;
            RS_CFG_LO:  bus_rdata[NPINS-1:0] = cfg_lo_q;
            RS_CFG_HI:  bus_rdata[NPINS-1:0] = cfg_hi_q;
            RS_MASK:    bus_rdata[NPINS-1:0] = mask_q;
            RS_STAT:    bus_rdata[NPINS-1:0] = stat_q;
            RS_ANYEDGE: bus_rdata[NPINS-1:0] = anyedge_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pinbank.sv
module gpio_pinbank import gpb_pkg::*; #(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq_lo,
    output logic             irq_hi
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] pad_lvl;
    logic [NPINS-1:0] stat_q;
    logic [NPINS-1:0] stat_clr;
    logic [NPINS-1:0] cfg_lo_q, cfg_hi_q, mask_q, anyedge_q;
    logic [NPINS-1:0] pend;

    gpb_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(pin_in), .synced(pad_lvl)
    );

    gpb_regs #(.NPINS(NPINS), .AW(AW)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_lvl(pad_lvl), .stat_q(stat_q),
        .dout_q(pin_out), .dir_q(pin_oe),
        .cfg_lo_q(cfg_lo_q), .cfg_hi_q(cfg_hi_q),
        .mask_q(mask_q), .anyedge_q(anyedge_q),
        .stat_clr(stat_clr)
    );

    gpb_sense #(.NPINS(NPINS)) u_sense (
        .clk(clk), .rst(rst), .lvl(pad_lvl),
        .cfg_lo(cfg_lo_q), .cfg_hi(cfg_hi_q), .any_edge(anyedge_q),
        .clr(stat_clr), .stat_q(stat_q)
    );

    assign pend   = stat_q & mask_q;
    assign irq_lo = |pend[HALF-1:0];
    assign irq_hi = |pend[NPINS-1:HALF];
endmodule

// File: rtl/gpb_checker.sv
module gpb_checker #(
    parameter int NPINS = 32,
    parameter int AW    = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq_lo,
    input logic             irq_hi,
    input logic [NPINS-1:0] stat_q,
    input logic [NPINS-1:0] mask_q
);
    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] clr_req;
    logic             unmapped;
    assign clr_req  = (bus_wr && 32'(bus_addr) == 32'h18) ? bus_wdata[NPINS-1:0] : '0;
    assign unmapped = (bus_addr[1:0] != 2'b00) || (32'(bus_addr) > 32'h1C);

    // R6: a status bit only drops after a clearing write with a one in that bit
    a_r6_sticky_status: assert property (@(posedge clk) disable iff (rst)
        (($past(stat_q) & ~stat_q & ~$past(clr_req)) == '0));

    // R9: a direction write shows on pin_oe one edge later
    a_r9_dir_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && 32'(bus_addr) == 32'h04) |=> (pin_oe == $past(bus_wdata[NPINS-1:0])));

    // R9: unmapped offsets read as zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (bus_rdata == 32'h0));

    // R8: a fully masked half never requests
    a_r8_irq_lo_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q[HALF-1:0] == '0) |-> !irq_lo);

    a_r8_irq_hi_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q[NPINS-1:HALF] == '0) |-> !irq_hi);
endmodule

bind gpio_pinbank gpb_checker #(.NPINS(NPINS), .AW(AW)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_oe(pin_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .stat_q(stat_q), .mask_q(mask_q)
);

// File: tb/tb_gpio_pinbank.sv
`timescale 1ns/1ps
module tb_gpio_pinbank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out, pin_oe;
    logic        irq_lo, irq_hi;

    int n_chk = 0;
    int n_bad = 0;

    gpio_pinbank dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
    endtask

    function automatic logic [31:0] lvl_hits(input int k, input logic [31:0] v);
        logic [31:0] r = '0;
        for (int p = 0; p < 32; p++) begin
            if ((p + k) % 5 == 0) r[p] = ~v[p];
            if ((p + k) % 5 == 1) r[p] = v[p];
        end
        return r;
    endfunction

    function automatic logic [31:0] edge_hits(input int k, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r = '0;
        for (int p = 0; p < 32; p++) begin
            if ((p + k) % 5 == 2) r[p] = b[p] & ~a[p];
            if ((p + k) % 5 == 3) r[p] = a[p] & ~b[p];
            if ((p + k) % 5 == 4) r[p] = a[p] ^ b[p];
        end
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [31:0] d, exp_s, m, lo_w, hi_w, any_w;
        logic [31:0] pa [6];
        logic [31:0] pb [6];
        pa = '{32'h0, 32'hFFFF_FFFF, 32'h0F0F_3C5A, 32'h1234_5678, 32'hAAAA_AAAA, 32'h0};
        pb = '{32'hFFFF_FFFF, 32'h0, 32'hF0F0_C3A5, 32'h1234_5678, 32'h5555_5555, 32'h0001_0001};

        // R1: reset state
        repeat (3) @(negedge clk);
        for (int o = 0; o < 8; o++) begin
            rd(8'(o * 4), d);
            check("R1 reset register", d, 32'h0);
        end
        check("R1 reset outputs", {pin_out | pin_oe}, 32'h0);
        check("R1 reset irq", {30'h0, irq_hi, irq_lo}, 32'h0);
        rst = 1'b0;
        @(negedge clk);

        // R2: output data and direction
        wr(8'h00, 32'hA5A5_1234);
        wr(8'h04, 32'hFFFF_0000);
        rd(8'h00, d); check("R2 dout readback", d, 32'hA5A5_1234);
        rd(8'h04, d); check("R2 dir readback", d, 32'hFFFF_0000);
        check("R2 pin_out", pin_out, 32'hA5A5_1234);
        check("R2 pin_oe", pin_oe, 32'hFFFF_0000);

        // R3: two-flop synchronized pad status
        bus_addr = 8'h08;
        pin_in = 32'h1357_9BDF;
        @(posedge clk); #1;
        check("R3 pad after one edge", bus_rdata, 32'h0);
        @(posedge clk); #1;
        check("R3 pad after two edges", bus_rdata, 32'h1357_9BDF);
        @(negedge clk);
        rd(8'h00, d); check("R2 dout not pin level", d, 32'hA5A5_1234);

        // R9: unmapped accesses
        rd(8'h20, d); check("R9 unmapped read 0x20", d, 32'h0);
        rd(8'h02, d); check("R9 unaligned read", d, 32'h0);
        rd(8'hFC, d); check("R9 unmapped read 0xFC", d, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h15, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R9 dout after unmapped write", d, 32'hA5A5_1234);
        rd(8'h04, d); check("R9 dir after unmapped write", d, 32'hFFFF_0000);
        rd(8'h14, d); check("R9 mask after unmapped write", d, 32'h0);

        // R4 R5 R7 R8: rotated mode sweep over all pins
        for (int k = 0; k < 5; k++) begin
            lo_w = '0; hi_w = '0; any_w = '0;
            for (int p = 0; p < 32; p++) begin
                int md;
                logic [1:0] code;
                md = (p + k) % 5;
                code = (md == 4) ? 2'(p % 4) : 2'(md);
                if (md == 4) any_w[p] = 1'b1;
                if (p < 16) lo_w[2*p +: 2] = code;
                else        hi_w[2*(p-16) +: 2] = code;
            end
            m = (32'h8000_0000 >> (k * 3)) | (32'h1 << (k * 4));
            wr(8'h0C, lo_w);
            wr(8'h10, hi_w);
            wr(8'h1C, any_w);
            wr(8'h14, m);
            for (int i = 0; i < 6; i++) begin
                pin_in = pa[i];
                repeat (5) @(negedge clk);
                wr(8'h18, 32'hFFFF_FFFF);
                exp_s = lvl_hits(k, pa[i]);
                rd(8'h18, d); check("R4 R5 R7 status after clear", d, exp_s);
                pin_in = pb[i];
                repeat (5) @(negedge clk);
                exp_s = lvl_hits(k, pa[i]) | lvl_hits(k, pb[i]) | edge_hits(k, pa[i], pb[i]);
                rd(8'h18, d); check("R4 R5 status after transition", d, exp_s);
                check("R8 irq lines", {30'h0, irq_hi, irq_lo},
                      {30'h0, |(exp_s & m & 32'hFFFF_0000), |(exp_s & m & 32'h0000_FFFF)});
            end
        end

        // R6 R8: write-one-to-clear and split request lines
        wr(8'h1C, 32'h0);
        wr(8'h0C, 32'hAAAA_AAAA);
        wr(8'h10, 32'hAAAA_AAAA);
        wr(8'h14, 32'h0);
        pin_in = 32'h0;
        repeat (5) @(negedge clk);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); check("R6 cleared", d, 32'h0);
        pin_in = 32'hFFFF_FFFF;
        repeat (5) @(negedge clk);
        rd(8'h18, d); check("R6 all rises latched", d, 32'hFFFF_FFFF);
        wr(8'h18, 32'h0000_FFFF);
        rd(8'h18, d); check("R6 partial clear", d, 32'hFFFF_0000);
        wr(8'h18, 32'h0);
        rd(8'h18, d); check("R6 zero write no effect", d, 32'hFFFF_0000);
        wr(8'h14, 32'h0001_0000);
        check("R8 upper line only", {30'h0, irq_hi, irq_lo}, 32'h2);
        wr(8'h14, 32'h0000_0001);
        check("R8 cleared lower bit masked in", {30'h0, irq_hi, irq_lo}, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); check("R6 full clear", d, 32'h0);

        // R7 R10: fresh edge in the same cycle as a clearing write
        pin_in = 32'h0;
        repeat (5) @(negedge clk);
        rd(8'h18, d); check("R10 falls ignored in rise mode", d, 32'h0);
        pin_in = 32'h10;
        repeat (5) @(negedge clk);
        rd(8'h18, d); check("R10 bit4 pending", d, 32'h10);
        pin_in = 32'h18;
        bus_addr = 8'h18;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        #0.5;
        check("R10 not yet after two edges", bus_rdata, 32'h10);
        wr(8'h18, 32'h18);
        rd(8'h18, d); check("R7 edge wins over clear", d, 32'h08);

        report();
        $finish;
    end
endmodule